// File: doc/BRIEF.md
# Piecewise-Linear Square Root and Sine/Cosine Evaluator

This block evaluates one of three elementary functions on a fixed-point operand: square root, sine or cosine. A function code selects which one. Each result comes from a single multiply and a single add. First the argument is reduced into a small primary interval. The interval is split into equal-width segments. The upper bits of the reduced argument pick a segment, and that segment has its own stored first-order coefficient pair. The remaining low bits are the interpolation distance inside the segment. The result is then scaled back to the output format.

Square root uses multiplicative reduction. A non-zero operand is shifted left by an even count 2k until it lies in [0.25, 1). The interval is covered by 384 segments, and the interpolated root is shifted right by k. Sine and cosine use additive reduction. The angle is an unsigned fraction of a full turn, so it wraps modulo 2π by itself. The top 9 bits address 512 segments over [0, 2) in units of π. Cosine is read from the sine table after a quarter-period offset is added to the angle.

The datapath is a fully pipelined stream. It accepts one operand every cycle. Each result appears a fixed number of cycles later, with its valid flag carried beside the data. The coefficient tables are computed at elaboration as integer constants.

Top module: `pwl_func_eval`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, out_valid stays low. Asserting reset discards every operand still in flight, so none of them ever produces a result.
- R2: Every cycle with in_valid high produces exactly one result with out_valid high, exactly 4 clock cycles later. Results come out in input order, and gaps in the input stream are kept as gaps at the output.
- R3: Function code 00 is square root. The operand is the unsigned fraction in_arg/2^16, and the result is the unsigned fraction out_result/2^16. For operands from 0x4000 upward, out_result is within 3 LSB of sqrt(in_arg)*256.
- R4: Square root of operands below 0x4000 is normalised by an even left shift, and the result is shifted right by half that count. The 3 LSB bound of R3 holds for every shift count. Operand 0x0001 gives 256, and every power of four gives the exact root.
- R5: Square root of operand 0x0000 gives 0.
- R6: Function code 01 is sine. The operand is an unsigned angle in units of π with 15 fractional bits, so 0x8000 is π. The result is two's complement with 14 fractional bits, so 0x4000 is +1.0. It is within 2 LSB of 16384*sin(π*in_arg/32768).
- R7: Function code 10 is cosine. It uses the same operand and result formats as R6, and the result is within 2 LSB of 16384*cos(π*in_arg/32768).
- R8: Angles wrap modulo 2π. Sine of angles just below 0x10000, and cosine of angles at or above 0xC000 (where the added quarter period overflows the operand width), still meet the 2 LSB bound.
- R9: Function code 11 is reserved. It produces a valid result of 0x0000.
- R10: Operands of different function codes in consecutive cycles each give their own correct result. All results are returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the valid pipeline |
| in_valid | input | 1 | Operand on in_func/in_arg is accepted this cycle |
| in_func | input | 2 | Function code: 00 square root, 01 sine, 10 cosine, 11 reserved |
| in_arg | input | IN_W (16) | Operand, interpreted as given for the selected function |
| out_valid | output | 1 | out_result holds a result this cycle |
| out_result | output | IN_W (16) | Result, format per function code |

## Verification
The hardest situations to reach from the ports are the extreme normalisation counts of the square root, and the cosine wrap where the quarter-period offset overflows the operand width. The stimulus table therefore steps single-bit operands through every even shift count, down to 0x0001. It also includes the exact operands that sit on segment boundaries, together with angles in the last quarter turn. The whole table is streamed back to back with mixed function codes, which exercises pipeline isolation. Separate directed phases insert bubbles, and they assert reset while results are still in flight.

// File: rtl/pwl_eval_pkg.sv
package pwl_eval_pkg;

   typedef enum logic [1:0] {
      FN_SQRT = 2'd0,
      FN_SIN  = 2'd1,
      FN_COS  = 2'd2,
      FN_RSV  = 2'd3
   } fn_e;

   // pi scaled by 2^30
   localparam longint PI_Q30 = 64'sd3373259426;

   // floor(sqrt(n)) for 0 <= n < 2^62, bitwise restoring method
   function automatic longint isqrt64(input longint n);
      longint rem;
      longint root;
      longint bitv;
      rem  = n;
      root = 0;
      bitv = 64'sd1 <<< 60;
      for (int j = 0; j < 31; j++) begin
         if (rem >= root + bitv) begin
            rem  = rem - (root + bitv);
            root = (root >>> 1) + bitv;
         end else begin
            root = root >>> 1;
         end
         bitv = bitv >>> 2;
      end
      return root;
   endfunction

   // root at the left edge of segment i, unsigned with w fractional bits
   function automatic longint sqrt_point(input int i, input int w, input int step);
      longint m;
      m = (64'sd1 <<< (w - 2)) + longint'(i) * longint'(step);
      return (isqrt64((m <<< w) <<< 2) + 1) >>> 1;
   endfunction

   // sine at the left edge of segment i, signed with w-2 fractional bits
   function automatic longint sine_point(input int i, input int w, input int idx_w);
      longint q;
      longint p;
      longint a;
      longint th;
      longint term;
      longint acc;
      bit     neg;
      q   = 64'sd1 <<< (w - 2);
      p   = (longint'(i) <<< (w - idx_w)) % (q * 4);
      neg = (p >= 2 * q);
      if (neg) p = p - 2 * q;
      a    = (p > q) ? (2 * q - p) : p;
      th   = (a * PI_Q30) / (2 * q);
      term = th;
      acc  = th;
      for (int n = 1; n <= 7; n++) begin
         term = (term * th) >>> 30;
         term = (term * th) >>> 30;
         term = -term / longint'((2 * n) * (2 * n + 1));
         acc  = acc + term;
      end
      acc = ((acc <<< (w - 2)) + (64'sd1 <<< 29)) >>> 30;
      return neg ? -acc : acc;
   endfunction

endpackage

// File: rtl/pwl_reduce.sv
module pwl_reduce
   import pwl_eval_pkg::*;
#(
   parameter int W        = 16,
   parameter int SQ_OFF_W = 7,
   parameter int TIX_W    = 9,
   parameter int SQ_SEGS  = 384,
   parameter int IX_W     = 9,
   parameter int OFF_W    = 7,
   parameter int KW       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             i_v,
   input  fn_e              i_fn,
   input  logic [W-1:0]     i_x,
   output logic             o_v,
   output fn_e              o_fn,
   output logic [IX_W-1:0]  o_idx,
   output logic [OFF_W-1:0] o_off,
   output logic [KW-1:0]    o_k,
   output logic             o_zero
);
   localparam int TR_OFF_W = W - TIX_W;
   localparam logic [W-1:0] QUARTER = W'(1 << (W - 2));

   logic [KW-1:0]    k;
   logic [W-1:0]     m;
   logic [W-1:0]     sq_rel;
   logic [W-1:0]     ang;
   logic             zero;
   logic [IX_W-1:0]  idx;
   logic [OFF_W-1:0] off;

   // normalisation count: highest non-zero bit pair decides the even shift
   always_comb begin
      k = '0;
      for (int j = 0; j < W / 2; j++) begin
         if (i_x[2*j +: 2] != 2'b00) k = KW'(W / 2 - 1 - j);
      end
   end

   assign m      = i_x << {k, 1'b0};
   assign sq_rel = m - QUARTER;
   assign ang    = (i_fn == FN_COS) ? (i_x + QUARTER) : i_x;
   assign zero   = (i_fn == FN_SQRT) && (i_x == '0);

   always_comb begin
      idx = '0;
      off = '0;
      unique case (i_fn)
         FN_SQRT: begin
            if (!zero) begin
               idx = IX_W'(sq_rel >> SQ_OFF_W);
               off = OFF_W'(sq_rel[SQ_OFF_W-1:0]);
            end
         end
         FN_SIN, FN_COS: begin
            idx = IX_W'(ang >> TR_OFF_W);
            off = OFF_W'(ang[TR_OFF_W-1:0]);
         end
         default: begin
            idx = '0;
            off = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) o_v <= 1'b0;
      else        o_v <= i_v;
   end

   always_ff @(posedge clk) begin
      o_fn   <= i_fn;
      o_idx  <= idx;
      o_off  <= off;
      o_k    <= (i_fn == FN_SQRT) ? k : '0;
      o_zero <= zero;
   end

   // R4: a non-zero root operand is normalised into [0.25, 1)
   p_norm_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (i_v && i_fn == FN_SQRT && i_x != '0) |-> (m[W-1 -: 2] != 2'b00));

   // R3: the root segment index stays inside the table
   p_seg_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (o_v && o_fn == FN_SQRT) |-> (int'(o_idx) < SQ_SEGS));

endmodule

// File: rtl/pwl_coef_rom.sv
module pwl_coef_rom
   import pwl_eval_pkg::*;
#(
   parameter int W       = 16,
   parameter int SQ_SEGS = 384,
   parameter int SQ_STEP = 128,
   parameter int SQ_IX_W = 9,
   parameter int TIX_W   = 9,
   parameter int IX_W    = 9,
   parameter int OFF_W   = 7,
   parameter int KW      = 3,
   parameter int CW      = 18
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 i_v,
   input  fn_e                  i_fn,
   input  logic [IX_W-1:0]      i_idx,
   input  logic [OFF_W-1:0]     i_off,
   input  logic [KW-1:0]        i_k,
   input  logic                 i_zero,
   output logic                 o_v,
   output fn_e                  o_fn,
   output logic signed [CW-1:0] o_c0,
   output logic signed [CW-1:0] o_c1,
   output logic [OFF_W-1:0]     o_off,
   output logic [KW-1:0]        o_k,
   output logic                 o_zero
);
   localparam int TR_SEGS = 1 << TIX_W;

   logic signed [CW-1:0] sq_c0 [SQ_SEGS];
   logic signed [CW-1:0] sq_c1 [SQ_SEGS];
   logic signed [CW-1:0] tr_c0 [TR_SEGS];
   logic signed [CW-1:0] tr_c1 [TR_SEGS];

   // chord through the two segment end points: base value and rise
   for (genvar i = 0; i < SQ_SEGS; i++) begin : g_sq_tab
      assign sq_c0[i] = CW'(sqrt_point(i, W, SQ_STEP));
      assign sq_c1[i] = CW'(sqrt_point(i + 1, W, SQ_STEP) - sqrt_point(i, W, SQ_STEP));
   end

   for (genvar i = 0; i < TR_SEGS; i++) begin : g_tr_tab
      assign tr_c0[i] = CW'(sine_point(i, W, TIX_W));
      assign tr_c1[i] = CW'(sine_point(i + 1, W, TIX_W) - sine_point(i, W, TIX_W));
   end

   logic signed [CW-1:0] c0_sel;
   logic signed [CW-1:0] c1_sel;

   always_comb begin
      c0_sel = '0;
      c1_sel = '0;
      unique case (i_fn)
         FN_SQRT: begin
            if (int'(i_idx) < SQ_SEGS) begin
               c0_sel = sq_c0[i_idx[SQ_IX_W-1:0]];
               c1_sel = sq_c1[i_idx[SQ_IX_W-1:0]];
            end
         end
         FN_SIN, FN_COS: begin
            c0_sel = tr_c0[i_idx[TIX_W-1:0]];
            c1_sel = tr_c1[i_idx[TIX_W-1:0]];
         end
         default: begin
            c0_sel = '0;
            c1_sel = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) o_v <= 1'b0;
      else        o_v <= i_v;
   end

   always_ff @(posedge clk) begin
      o_fn   <= i_fn;
      o_c0   <= c0_sel;
      o_c1   <= c1_sel;
      o_off  <= i_off;
      o_k    <= i_k;
      o_zero <= i_zero;
   end

endmodule

// File: rtl/pwl_mac.sv
module pwl_mac
   import pwl_eval_pkg::*;
#(
   parameter int W        = 16,
   parameter int SQ_OFF_W = 7,
   parameter int TR_OFF_W = 7,
   parameter int OFF_W    = 7,
   parameter int KW       = 3,
   parameter int CW       = 18
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 i_v,
   input  fn_e                  i_fn,
   input  logic signed [CW-1:0] i_c0,
   input  logic signed [CW-1:0] i_c1,
   input  logic [OFF_W-1:0]     i_off,
   input  logic [KW-1:0]        i_k,
   input  logic                 i_zero,
   output logic                 o_v,
   output fn_e                  o_fn,
   output logic signed [CW-1:0] o_r,
   output logic [KW-1:0]        o_k,
   output logic                 o_zero
);
   localparam int PW = CW + OFF_W + 1;

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] step_sq;
   logic signed [PW-1:0] step_tr;
   logic signed [CW-1:0] sum;

   // the single multiply and single add of the first-order polynomial
   assign prod    = PW'(i_c1) * $signed({1'b0, i_off});
   assign step_sq = prod >>> SQ_OFF_W;
   assign step_tr = prod >>> TR_OFF_W;
   assign sum     = i_c0 + CW'((i_fn == FN_SQRT) ? step_sq : step_tr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) o_v <= 1'b0;
      else        o_v <= i_v;
   end

   always_ff @(posedge clk) begin
      o_fn   <= i_fn;
      o_r    <= sum;
      o_k    <= i_k;
      o_zero <= i_zero;
   end

   // R3: the interpolated root of a normalised operand lies in [0.5, 1)
   p_sqrt_mant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (o_v && o_fn == FN_SQRT && !o_zero) |->
         (o_r >= CW'(1 << (W - 1)) && o_r < CW'(1 << W)));

endmodule

// File: rtl/pwl_recon.sv
module pwl_recon
   import pwl_eval_pkg::*;
#(
   parameter int W  = 16,
   parameter int KW = 3,
   parameter int CW = 18
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 i_v,
   input  fn_e                  i_fn,
   input  logic signed [CW-1:0] i_r,
   input  logic [KW-1:0]        i_k,
   input  logic                 i_zero,
   output logic                 o_v,
   output logic [W-1:0]         o_res
);
   logic [W-1:0] res;

   always_comb begin
      unique case (i_fn)
         FN_SQRT: res = i_zero ? '0 : (i_r[W-1:0] >> i_k);
         FN_SIN, FN_COS: res = i_r[W-1:0];
         default: res = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) o_v <= 1'b0;
      else        o_v <= i_v;
   end

   always_ff @(posedge clk) begin
      o_res <= res;
   end

   // R5: a zero root operand gives a zero result
   p_zero_root_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (i_v && i_fn == FN_SQRT && i_zero) |=> (o_res == '0));

   // R6: a trigonometric result never exceeds unity in magnitude
   p_trig_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (i_v && (i_fn == FN_SIN || i_fn == FN_COS)) |=>
         (int'($signed(o_res)) <= (1 << (W - 2)) &&
          int'($signed(o_res)) >= -(1 << (W - 2))));

   // R9: the reserved code yields zero
   p_resv_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (i_v && i_fn == FN_RSV) |=> (o_res == '0));

endmodule

// File: rtl/pwl_func_eval.sv
module pwl_func_eval
   import pwl_eval_pkg::*;
#(
   parameter int IN_W       = 16,
   parameter int SQRT_SEGS  = 384,
   parameter int TRIG_IDX_W = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [1:0]      in_func,
   input  logic [IN_W-1:0] in_arg,
   output logic            out_valid,
   output logic [IN_W-1:0] out_result
);
   localparam int SQ_SPAN  = 3 * (1 << (IN_W - 2));
   localparam int SQ_STEP  = SQ_SPAN / SQRT_SEGS;
   localparam int SQ_OFF_W = $clog2(SQ_STEP);
   localparam int SQ_IX_W  = $clog2(SQRT_SEGS);
   localparam int TR_OFF_W = IN_W - TRIG_IDX_W;
   localparam int OFF_W    = (SQ_OFF_W > TR_OFF_W) ? SQ_OFF_W : TR_OFF_W;
   localparam int IX_W     = (SQ_IX_W > TRIG_IDX_W) ? SQ_IX_W : TRIG_IDX_W;
   localparam int KW       = $clog2(IN_W / 2);
   localparam int CW       = IN_W + 2;
   localparam int LAT      = 4;

   if (IN_W % 2 != 0 || IN_W < 8 || IN_W > 24) begin : g_bad_width
      $error("IN_W must be even and within 8..24");
   end
   if (SQ_STEP * SQRT_SEGS != SQ_SPAN || SQ_STEP != (1 << SQ_OFF_W)) begin : g_bad_segs
      $error("SQRT_SEGS must split the root interval into power-of-two steps");
   end
   if (TRIG_IDX_W < 2 || TRIG_IDX_W >= IN_W) begin : g_bad_trig
      $error("TRIG_IDX_W must leave at least one offset bit");
   end

   fn_e                  s1_fn, s2_fn, s3_fn;
   logic                 s1_v, s2_v, s3_v;
   logic [IX_W-1:0]      s1_idx;
   logic [OFF_W-1:0]     s1_off, s2_off;
   logic [KW-1:0]        s1_k, s2_k, s3_k;
   logic                 s1_zero, s2_zero, s3_zero;
   logic signed [CW-1:0] s2_c0, s2_c1, s3_r;

   pwl_reduce #(
      .W(IN_W), .SQ_OFF_W(SQ_OFF_W), .TIX_W(TRIG_IDX_W), .SQ_SEGS(SQRT_SEGS),
      .IX_W(IX_W), .OFF_W(OFF_W), .KW(KW)
   ) u_reduce (
      .clk(clk), .rst_n(rst_n), .i_v(in_valid), .i_fn(fn_e'(in_func)), .i_x(in_arg),
      .o_v(s1_v), .o_fn(s1_fn), .o_idx(s1_idx), .o_off(s1_off), .o_k(s1_k),
      .o_zero(s1_zero)
   );

   pwl_coef_rom #(
      .W(IN_W), .SQ_SEGS(SQRT_SEGS), .SQ_STEP(SQ_STEP), .SQ_IX_W(SQ_IX_W),
      .TIX_W(TRIG_IDX_W), .IX_W(IX_W), .OFF_W(OFF_W), .KW(KW), .CW(CW)
   ) u_rom (
      .clk(clk), .rst_n(rst_n), .i_v(s1_v), .i_fn(s1_fn), .i_idx(s1_idx),
      .i_off(s1_off), .i_k(s1_k), .i_zero(s1_zero),
      .o_v(s2_v), .o_fn(s2_fn), .o_c0(s2_c0), .o_c1(s2_c1), .o_off(s2_off),
      .o_k(s2_k), .o_zero(s2_zero)
   );

   pwl_mac #(
      .W(IN_W), .SQ_OFF_W(SQ_OFF_W), .TR_OFF_W(TR_OFF_W), .OFF_W(OFF_W),
      .KW(KW), .CW(CW)
   ) u_mac (
      .clk(clk), .rst_n(rst_n), .i_v(s2_v), .i_fn(s2_fn), .i_c0(s2_c0),
      .i_c1(s2_c1), .i_off(s2_off), .i_k(s2_k), .i_zero(s2_zero),
      .o_v(s3_v), .o_fn(s3_fn), .o_r(s3_r), .o_k(s3_k), .o_zero(s3_zero)
   );

   pwl_recon #(
      .W(IN_W), .KW(KW), .CW(CW)
   ) u_recon (
      .clk(clk), .rst_n(rst_n), .i_v(s3_v), .i_fn(s3_fn), .i_r(s3_r),
      .i_k(s3_k), .i_zero(s3_zero), .o_v(out_valid), .o_res(out_result)
   );

   // cycles since reset release, saturating, for the latency check
   logic [2:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst < 3'(LAT)) since_rst <= since_rst + 3'd1;
   end

   // R2: valid out follows valid in by exactly four cycles
   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 3'(LAT)) |-> (out_valid == $past(in_valid, 4)));

   // R1: nothing emerges before an operand could have crossed the pipe
   p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < 3'(LAT)) |-> !out_valid);

endmodule

// File: tb/pwl_func_eval_bench.sv
module pwl_func_eval_bench;
   localparam int  W  = 16;
   localparam int  NV = 40;
   localparam real PI = 3.14159265358979323846;

   // {function code, operand}
   localparam logic [17:0] VEC [NV] = '{
      {2'd0, 16'h4000}, {2'd0, 16'hFFFF}, {2'd0, 16'h8000}, {2'd0, 16'h5555},
      {2'd0, 16'h407F}, {2'd0, 16'h4080}, {2'd0, 16'hC000}, {2'd0, 16'h0000},
      {2'd0, 16'h0001}, {2'd0, 16'h0002}, {2'd0, 16'h0004}, {2'd0, 16'h0010},
      {2'd0, 16'h0040}, {2'd0, 16'h0100}, {2'd0, 16'h0400}, {2'd0, 16'h1000},
      {2'd0, 16'h3FFF}, {2'd0, 16'h0003}, {2'd0, 16'h00FF},
      {2'd1, 16'h0000}, {2'd1, 16'h4000}, {2'd1, 16'h8000}, {2'd1, 16'hC000},
      {2'd1, 16'h2000}, {2'd1, 16'h1234}, {2'd1, 16'h007F}, {2'd1, 16'h0080},
      {2'd1, 16'hA5A5}, {2'd1, 16'hFFFF}, {2'd1, 16'hF00F},
      {2'd2, 16'h0000}, {2'd2, 16'h4000}, {2'd2, 16'h8000}, {2'd2, 16'h3333},
      {2'd2, 16'hC000}, {2'd2, 16'hFFFF}, {2'd2, 16'hE123},
      {2'd3, 16'h1234}, {2'd0, 16'h0000}, {2'd3, 16'hFFFF}
   };

   logic          clk;
   logic          rst_n;
   logic          in_valid;
   logic [1:0]    in_func;
   logic [W-1:0]  in_arg;
   logic          out_valid;
   logic [W-1:0]  out_result;

   pwl_func_eval u_pwl_func_eval (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_func(in_func),
      .in_arg(in_arg), .out_valid(out_valid), .out_result(out_result)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_checks = 0;
   int n_fail   = 0;
   logic [17:0] sent_v [256];
   int          sent_c [256];
   int wr = 0;
   int rd = 0;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic string tag_of(input logic [17:0] v);
      case (v[17:16])
         2'd0: return (v[15:0] == 16'h0) ? "R5" : (v[15:0] < 16'h4000) ? "R4" : "R3";
         2'd1: return (v[15:0] >= 16'hF000) ? "R8" : "R6";
         2'd2: return (v[15:0] >= 16'hC000) ? "R8" : "R7";
         default: return "R9";
      endcase
   endfunction

   function automatic real ideal(input logic [17:0] v);
      real a;
      a = real'(v[15:0]);
      case (v[17:16])
         2'd0: return $sqrt(a) * 256.0;
         2'd1: return 16384.0 * $sin(PI * a / 32768.0);
         2'd2: return 16384.0 * $cos(PI * a / 32768.0);
         default: return 0.0;
      endcase
   endfunction

   function automatic real tol(input logic [17:0] v);
      case (v[17:16])
         2'd0: return (v[15:0] == 16'h0) ? 0.0 : 3.0;
         2'd1, 2'd2: return 2.0;
         default: return 0.0;
      endcase
   endfunction

   // result monitor: R2 latency plus per-function value checks
   always @(negedge clk) begin
      if (!rst_n) begin
         rd = wr;
      end else if (out_valid) begin
         if (rd == wr) begin
            check(1'b0, "R2 spurious result", 1, 0);
         end else begin
            logic [17:0] v;
            int  act;
            real d;
            v   = sent_v[rd % 256];
            act = (v[17:16] == 2'd1 || v[17:16] == 2'd2) ? int'($signed(out_result))
                                                         : int'(out_result);
            d   = real'(act) - ideal(v);
            check(d <= tol(v) && d >= -tol(v), tag_of(v), act, $rtoi(ideal(v) + 0.5));
            check(cyc - sent_c[rd % 256] == 4, "R2 latency", cyc - sent_c[rd % 256], 4);
            rd = rd + 1;
         end
      end
   end

   task automatic send(input logic [17:0] v);
      @(negedge clk);
      in_valid = 1'b1;
      in_func  = v[17:16];
      in_arg   = v[15:0];
      sent_v[wr % 256] = v;
      sent_c[wr % 256] = cyc;
      wr = wr + 1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 20000);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_run();
   end

   initial begin
      int seen;
      int base;
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_func  = 2'd0;
      in_arg   = '0;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1 in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check(out_valid == 1'b0, "R1 after release", int'(out_valid), 0);
      end

      // back-to-back table walk, mixed functions every cycle (R10)
      for (int i = 0; i < NV; i++) send(VEC[i]);
      idle(8);
      check(rd == NV, "R10 all results returned", rd, NV);

      // bubbles in the stream keep their spacing (R2)
      base = wr;
      send({2'd0, 16'h0009});
      idle(2);
      send({2'd1, 16'h6000});
      idle(1);
      send({2'd2, 16'h9ABC});
      send({2'd0, 16'h0000});
      idle(8);
      check(rd == base + 4, "R2 gapped stream count", rd - base, 4);

      // reset while operands are in flight: all of them are dropped (R1)
      send({2'd0, 16'h7777});
      send({2'd1, 16'h1111});
      send({2'd2, 16'h2222});
      @(negedge clk);
      in_valid = 1'b0;
      rst_n    = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 flush during reset", int'(out_valid), 0);
      rst_n = 1'b1;
      seen  = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (out_valid) seen++;
      end
      check(seen == 0, "R1 no stale result", seen, 0);

      // stream works again after the mid-flight reset (R10)
      base = rd;
      send({2'd1, 16'h4000});
      send({2'd0, 16'h0001});
      send({2'd3, 16'h0001});
      idle(8);
      check(rd == base + 3, "R10 stream after reset", rd - base, 3);

      finish_run();
   end

endmodule